// File: doc/BRIEF.md
# Line-Locked Feedback Clock Divider

This block turns a fast pixel clock into a line-rate feedback signal that a phase detector compares against incoming horizontal sync. The clock first passes a divide-by-two prescaler, which produces a half-rate enable tick. A modulo-N counter then advances on each tick, so the feedback waveform repeats every 2N input clocks. A 3-bit select picks N from eight preset divisors, and a new selection is picked up at the next counter wrap.

A path-select input chooses where the feedback comes from. When it is high, the internal divider drives the feedback and also drives the shared divider pin. When it is low, the pin is released and an external divider's output is used. That signal passes through a synchronizer first. A fast-lock mode accepts two requests from the phase detector: realign, which restarts the divide period at once, and inhibit, which stalls the counter for one half-rate step. Both requests are honoured only in this mode. In this mode the spacing of the feedback edges may be irregular, and that is allowed.

Top module: `line_fb_divider`

## Requirements
- R1: With `rst_ni` sampled low at a clock edge, the prescaler phase and the counter go to zero. The synchronizer stages clear and the selected divisor is loaded. While the internal path is selected, `fb_o` is high in the reset state.
- R2: The counter advances once every two input clocks. After reset is released, `fb_o` stays high for 2*floor(N/2) clocks, counting the reset state as the first.
- R3: `div_sel_i` values 0 to 7 select N = 780, 858, 864, 910, 944, 1135, 1250, 1716. In steady state, rising edges of the internal feedback are 2N clocks apart.
- R4: The feedback rises when the counter wraps to zero. It is high for 2*floor(N/2) clocks of each period.
- R5: A change of `div_sel_i` within a period does not alter that period; the period after the next wrap uses the new N.
- R6: With `int_div_en_i` high, `ext_fb_oe_o` is 1 and both `ext_fb_o` and `fb_o` carry the internal feedback.
- R7: With `int_div_en_i` low, `ext_fb_oe_o` and `ext_fb_o` are 0. `fb_o` equals `ext_fb_i` delayed by SYNC_STAGES clocks; the default is 2.
- R8: In fast-lock mode, a realign request sampled at an edge sets the counter and prescaler to zero. `fb_o` is high in the next cycle, and the following rising edge comes 2N clocks after that cycle.
- R9: In fast-lock mode, an inhibit request that coincides with a half-rate tick holds the counter for that tick. A two-clock inhibit lengthens the current period by exactly 2 clocks.
- R10: If realign and inhibit are requested together in fast-lock mode, the realign wins.
- R11: With `fast_lock_i` low, realign and inhibit requests have no effect, and the period stays 2N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast pixel clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| div_sel_i | input | 3 | Preset divisor select |
| int_div_en_i | input | 1 | 1: internal divider drives feedback; 0: external divider input used |
| fast_lock_i | input | 1 | Enables realign and inhibit requests |
| realign_req_i | input | 1 | Restart the divide period (fast lock only) |
| inhibit_req_i | input | 1 | Stall the counter one half-rate step (fast lock only) |
| ext_fb_i | input | 1 | Feedback from an external divider |
| ext_fb_o | output | 1 | Internal feedback driven toward the divider pin |
| ext_fb_oe_o | output | 1 | Drive enable for the divider pin |
| fb_o | output | 1 | Selected feedback to the phase detector |

## Verification
The bench measures whole periods and high times at the output, rather than peeking at the counter. A missing prescaler would therefore show up as a halved period, and an off-by-one wrap as a period 2 clocks off.

Several cases are aimed at specific faults:
- A select change in mid-period catches a divisor latched too early, which would shorten the current period.
- A realign issued while the output is low must give a rise one clock later. Issued while the output is high, it must stretch the period by the offset.
- A combined realign and inhibit separates the two priorities: the wrong order yields 2N+2 instead of a restart.
- Requests made outside fast lock must leave the period at exactly 2N.
- The external path is checked against a two-clock delayed copy of a random input pattern.

// File: rtl/line_div_pkg.sv
package line_div_pkg;

  localparam int unsigned CNT_W    = 11;
  localparam int unsigned SEL_W    = 3;
  localparam int unsigned NUM_DIVS = 1 << SEL_W;

  typedef logic [CNT_W-1:0] cnt_t;
  typedef logic [SEL_W-1:0] sel_t;

  // Preset half-rate divisors, one per select code.
  function automatic cnt_t div_value(sel_t s);
    cnt_t n;
    case (s)
      3'd0:    n = cnt_t'(780);
      3'd1:    n = cnt_t'(858);
      3'd2:    n = cnt_t'(864);
      3'd3:    n = cnt_t'(910);
      3'd4:    n = cnt_t'(944);
      3'd5:    n = cnt_t'(1135);
      3'd6:    n = cnt_t'(1250);
      default: n = cnt_t'(1716);
    endcase
    return n;
  endfunction

  // Number of half-rate steps the feedback stays high.
  function automatic cnt_t half_of(cnt_t n);
    return n >> 1;
  endfunction

  // True when the count sits on the last step of the period.
  function automatic logic at_last(cnt_t c, cnt_t n);
    return c == (n - cnt_t'(1));
  endfunction

endpackage

// File: rtl/line_div_prescale.sv
module line_div_prescale (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic tick_o
);

  logic phase_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni || restart_i) phase_q <= 1'b0;
    else                      phase_q <= ~phase_q;
  end

  // Half-rate enable: one cycle in two.
  assign tick_o = phase_q;

endmodule

// File: rtl/line_div_counter.sv
module line_div_counter
  import line_div_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic realign_i,
  input  logic inhibit_i,
  input  sel_t div_sel_i,
  output cnt_t cnt_o,
  output cnt_t div_o,
  output logic wrap_o,
  output logic fb_o
);

  cnt_t cnt_q;
  cnt_t div_q;
  logic step_w;

  assign step_w = tick_i & ~inhibit_i & ~realign_i;
  assign wrap_o = step_w & at_last(cnt_q, div_q);

  always_ff @(posedge clk_i) begin
    if (!rst_ni || realign_i) begin
      cnt_q <= '0;
      div_q <= div_value(div_sel_i);
    end else if (wrap_o) begin
      cnt_q <= '0;
      div_q <= div_value(div_sel_i);
    end else if (step_w) begin
      cnt_q <= cnt_q + cnt_t'(1);
    end
  end

  assign fb_o  = cnt_q < half_of(div_q);
  assign cnt_o = cnt_q;
  assign div_o = div_q;

endmodule

// File: rtl/line_div_fbmux.sv
module line_div_fbmux #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic int_en_i,
  input  logic int_fb_i,
  input  logic ext_fb_i,
  output logic fb_o,
  output logic ext_fb_o,
  output logic ext_fb_oe_o
);

  logic ext_sync_w;

  generate
    if (SYNC_STAGES == 0) begin : g_nosync
      assign ext_sync_w = ext_fb_i;
    end else begin : g_sync
      logic [SYNC_STAGES-1:0] sync_q;
      always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
          sync_q <= '0;
        end else begin
          sync_q[0] <= ext_fb_i;
          for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
        end
      end
      assign ext_sync_w = sync_q[SYNC_STAGES-1];
    end
  endgenerate

  assign ext_fb_oe_o = int_en_i;
  assign ext_fb_o    = int_en_i & int_fb_i;
  assign fb_o        = int_en_i ? int_fb_i : ext_sync_w;

endmodule

// File: rtl/line_fb_divider.sv
module line_fb_divider
  import line_div_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] div_sel_i,
  input  logic       int_div_en_i,
  input  logic       fast_lock_i,
  input  logic       realign_req_i,
  input  logic       inhibit_req_i,
  input  logic       ext_fb_i,
  output logic       ext_fb_o,
  output logic       ext_fb_oe_o,
  output logic       fb_o
);

  logic tick_w;
  logic realign_w;
  logic inhibit_w;
  logic wrap_w;
  logic int_fb_w;
  cnt_t cnt_w;
  cnt_t div_w;

  // Requests count only in fast lock; realign outranks inhibit.
  assign realign_w = fast_lock_i & realign_req_i;
  assign inhibit_w = fast_lock_i & inhibit_req_i & ~realign_w;

  line_div_prescale u_prescale (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (realign_w),
    .tick_o    (tick_w)
  );

  line_div_counter u_counter (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_w),
    .realign_i (realign_w),
    .inhibit_i (inhibit_w),
    .div_sel_i (sel_t'(div_sel_i)),
    .cnt_o     (cnt_w),
    .div_o     (div_w),
    .wrap_o    (wrap_w),
    .fb_o      (int_fb_w)
  );

  line_div_fbmux #(.SYNC_STAGES(SYNC_STAGES)) u_fbmux (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .int_en_i    (int_div_en_i),
    .int_fb_i    (int_fb_w),
    .ext_fb_i    (ext_fb_i),
    .fb_o        (fb_o),
    .ext_fb_o    (ext_fb_o),
    .ext_fb_oe_o (ext_fb_oe_o)
  );

endmodule

// File: rtl/line_div_chk.sv
module line_div_chk
  import line_div_pkg::*;
(
  input logic clk_i,
  input logic rst_ni,
  input logic tick,
  input logic realign,
  input logic inhibit,
  input logic wrap,
  input logic fast_lock,
  input logic int_en,
  input logic int_fb,
  input cnt_t cnt,
  input cnt_t div,
  input logic fb_o,
  input logic ext_fb_o,
  input logic ext_fb_oe_o
);

  // R2
  tick_alternate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick |=> !tick);

  // R3
  cnt_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt < div);

  // R4
  wrap_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |=> (cnt == '0) && int_fb);

  // R8
  realign_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    realign |=> (cnt == '0) && !tick && int_fb);

  // R9
  inhibit_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inhibit && tick) |=> $stable(cnt));

  // R11
  free_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fast_lock && tick && !wrap) |=> (cnt == cnt_t'($past(cnt) + cnt_t'(1))));

  // R6
  int_path_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_en |-> (ext_fb_oe_o && (ext_fb_o == fb_o) && (fb_o == int_fb)));

  // R7
  ext_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !int_en |-> (!ext_fb_oe_o && !ext_fb_o));

endmodule

bind line_fb_divider line_div_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick        (tick_w),
  .realign     (realign_w),
  .inhibit     (inhibit_w),
  .wrap        (wrap_w),
  .fast_lock   (fast_lock_i),
  .int_en      (int_div_en_i),
  .int_fb      (int_fb_w),
  .cnt         (cnt_w),
  .div         (div_w),
  .fb_o        (fb_o),
  .ext_fb_o    (ext_fb_o),
  .ext_fb_oe_o (ext_fb_oe_o)
);

// File: tb/line_fb_divider_bench.sv
`timescale 1ns/1ps
module line_fb_divider_bench;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] div_sel = 3'd0;
  logic       int_en = 1'b1;
  logic       fast_lock = 1'b0;
  logic       realign = 1'b0;
  logic       inhibit = 1'b0;
  logic       ext_in = 1'b0;
  logic       ext_out, ext_oe, fb;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  line_fb_divider u_line_fb_divider (
    .clk_i(clk), .rst_ni(rst_ni), .div_sel_i(div_sel), .int_div_en_i(int_en),
    .fast_lock_i(fast_lock), .realign_req_i(realign), .inhibit_req_i(inhibit),
    .ext_fb_i(ext_in), .ext_fb_o(ext_out), .ext_fb_oe_o(ext_oe), .fb_o(fb)
  );

  function automatic int exp_n(int s);
    int tbl[8] = '{780, 858, 864, 910, 944, 1135, 1250, 1716};
    return tbl[s];
  endfunction

  function automatic int exp_high(int s);
    return 2 * (exp_n(s) / 2);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // act: 0 none, 1 inhibit 2 clk, 2 realign, 3 realign+inhibit, 4 select arg
  task automatic measure(input bit cont, input int act, input int off, input int arg,
                         output int per, output int hi, output bit mid);
    bit prev, cur;
    int j;
    mid = 1'b0;
    if (!cont) begin
      prev = 1'b1;
      for (int g = 0; g < 8000; g++) begin
        @(negedge clk);
        cur = fb;
        if (!prev && cur) break;
        prev = cur;
      end
    end
    prev = 1'b1;
    per = 1; hi = 1; j = 0;
    for (int g = 0; g < 8000; g++) begin
      if (j == off) begin
        case (act)
          1: inhibit = 1'b1;
          2: realign = 1'b1;
          3: begin realign = 1'b1; inhibit = 1'b1; end
          4: div_sel = arg[2:0];
          default: ;
        endcase
      end
      if (j == off + 1) realign = 1'b0;
      if (j == off + 2) inhibit = 1'b0;
      @(negedge clk);
      j++;
      cur = fb;
      if (j == off + 1) mid = cur;
      if (!prev && cur) break;
      per++;
      if (cur) hi++;
      prev = cur;
    end
    realign = 1'b0;
    inhibit = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int per, hi, s, h0, h1;
    bit mid;
    void'($urandom(32'd5171));

    // R1: reset state
    repeat (3) @(negedge clk);
    check(fb == 1'b1, "R1 fb in reset", fb, 1);
    check(ext_oe == 1'b1, "R1 oe in reset", ext_oe, 1);
    // R2: first high run after release, N=780
    rst_ni = 1'b1;
    h0 = 1;
    for (int g = 0; g < 4000; g++) begin
      @(negedge clk);
      if (!fb) break;
      h0++;
    end
    check(h0 == exp_high(0), "R2 first high run", h0, exp_high(0));

    // R3 R4: steady state for select 0
    measure(1'b0, 0, 0, 0, per, hi, mid);
    check(per == 2 * exp_n(0), "R3 period sel0", per, 2 * exp_n(0));
    check(hi == exp_high(0), "R4 high sel0", hi, exp_high(0));
    check(ext_out == fb && ext_oe, "R6 pin mirrors fb", ext_out, fb);

    // R5: select change mid-period takes effect after the wrap
    measure(1'b1, 4, 10, 7, per, hi, mid);
    check(per == 2 * exp_n(0), "R5 old period kept", per, 2 * exp_n(0));
    measure(1'b1, 0, 0, 0, per, hi, mid);
    check(per == 2 * exp_n(7), "R5 new period", per, 2 * exp_n(7));
    check(hi == exp_high(7), "R4 high sel7", hi, exp_high(7));

    // R3 R4: constrained random selects
    for (int it = 0; it < 5; it++) begin
      s = int'($urandom_range(0, 7));
      div_sel = s[2:0];
      measure(1'b0, 0, 0, 0, per, hi, mid);
      measure(1'b1, 0, 0, 0, per, hi, mid);
      check(per == 2 * exp_n(s), "R3 random period", per, 2 * exp_n(s));
      check(hi == exp_high(s), "R4 random high", hi, exp_high(s));
    end

    div_sel = 3'd0;
    measure(1'b0, 0, 0, 0, per, hi, mid);

    // R11: requests ignored outside fast lock
    measure(1'b1, 3, 10, 0, per, hi, mid);
    check(per == 2 * exp_n(0), "R11 requests ignored", per, 2 * exp_n(0));

    fast_lock = 1'b1;
    // R9: inhibit stretches by 2 clocks
    measure(1'b1, 1, 10, 0, per, hi, mid);
    check(per == 2 * exp_n(0) + 2, "R9 inhibit period", per, 2 * exp_n(0) + 2);
    check(hi == exp_high(0) + 2, "R9 inhibit high", hi, exp_high(0) + 2);

    // R8: realign while high restarts the period
    measure(1'b1, 2, 10, 0, per, hi, mid);
    check(mid == 1'b1, "R8 high after realign", mid, 1);
    check(per == 11 + 2 * exp_n(0), "R8 realign while high", per, 11 + 2 * exp_n(0));

    // R8: realign while low gives a rise one clock later
    measure(1'b1, 2, 800, 0, per, hi, mid);
    check(per == 801, "R8 realign while low", per, 801);
    measure(1'b1, 0, 0, 0, per, hi, mid);
    check(per == 2 * exp_n(0), "R8 period after realign", per, 2 * exp_n(0));

    // R10: realign wins over inhibit
    measure(1'b1, 3, 10, 0, per, hi, mid);
    check(per == 11 + 2 * exp_n(0), "R10 realign priority", per, 11 + 2 * exp_n(0));
    fast_lock = 1'b0;

    // R7: external path
    @(negedge clk);
    int_en = 1'b0;
    ext_in = 1'b0;
    h0 = 0; h1 = 0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      if (i > 0) begin
        check(fb == h1[0], "R7 delayed external", fb, h1);
        check(!ext_oe && !ext_out, "R7 pin released", {ext_oe, ext_out}, 0);
      end
      h1 = h0;
      h0 = int'($urandom_range(0, 1));
      ext_in = h0[0];
    end

    // R6: back to internal
    int_en = 1'b1;
    @(negedge clk);
    check(ext_oe == 1'b1 && ext_out == fb, "R6 internal restored", ext_oe, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule